// File: doc/BRIEF.md
# Next Program Counter Selector

This block chooses the address of the next instruction for a pipelined 16-bit processor and holds the program counter register. Each cycle it forms a sequential successor of the current PC. The step is 2 bytes for a plain instruction and 4 bytes for an instruction followed by a 16-bit immediate word. It also evaluates the jump-type field against the carry, negative and zero flags.

The candidate addresses then pass through a fixed three-level priority chain. A qualified jump replaces the sequential successor. An exception replaces the result of that level with the handler address. A return or return-from-interrupt replaces everything with the saved return address. The chosen address is loaded into the PC on the rising clock edge whenever the stall input is low. A synchronous active-low reset loads the code start address, which is supplied from outside.

Top module: `npc_selector`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC register loads `start_addr_i`, and `pc_o` shows that value after the edge.
- R2: With no jump taken, no exception and no return, `next_pc_o` equals `pc_o + 2` when `has_offset_i` is 0.
- R3: With no jump taken, no exception and no return, `next_pc_o` equals `pc_o + 4` when `has_offset_i` is 1. Both additions wrap modulo 2^ADDR_W.
- R4: `jump_type_i` codes work as follows: 3'b001 takes the jump when `flag_z_i` is 1, 3'b010 when `flag_n_i` is 1, 3'b011 when `flag_c_i` is 1, and 3'b100 always takes it. `jump_taken_o` reports the outcome.
- R5: Codes 3'b000, 3'b101, 3'b110 and 3'b111 never take a jump, whatever the flags, so `next_pc_o` stays the sequential successor.
- R6: When `jump_taken_o` is 1 and neither `exc_i` nor `ret_i` is high, `next_pc_o` equals `jump_dest_i`.
- R7: When `exc_i` is 1 and `ret_i` is 0, `next_pc_o` equals `exc_addr_i`, regardless of jump outcome or offset.
- R8: When `ret_i` is 1, `next_pc_o` equals `ret_addr_i`, regardless of exception, jump and offset.
- R9: While `stall_i` is 1 (out of reset), `pc_o` keeps its value across the rising edge.
- R10: While `stall_i` is 0 (out of reset), `pc_o` takes, after the rising edge, the `next_pc_o` value present before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Holds the PC when high |
| start_addr_i | input | ADDR_W | Code start address loaded at reset |
| has_offset_i | input | 1 | Current instruction carries an immediate word |
| jump_type_i | input | 3 | Jump-type code |
| flag_c_i | input | 1 | Carry flag |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| jump_dest_i | input | ADDR_W | Jump destination address |
| exc_i | input | 1 | Exception signalled |
| exc_addr_i | input | ADDR_W | Exception handler address |
| ret_i | input | 1 | Return or return-from-interrupt |
| ret_addr_i | input | ADDR_W | Saved return address |
| pc_o | output | ADDR_W | Current program counter |
| next_pc_o | output | ADDR_W | Selected next program counter |
| jump_taken_o | output | 1 | Flag-qualified jump outcome |

## Verification
The overrides can collide in one cycle. A taken jump can meet an exception, and an exception can meet a return. The bench provokes both collisions with directed cycles and again with random strobes that fire often. A behavioural priority model judges every cycle: the return address must win over the handler address, and the handler address must win over the jump destination. The model also follows the PC register across stalls and wrap at the top of the address space.

// File: rtl/npc_pkg.sv
// Shared constants and types for the next-PC selector.
// Assumes byte addressing with 16-bit instruction words.
package npc_pkg;
    localparam int JT_W       = 3;
    localparam int STEP_PLAIN = 2;
    localparam int STEP_OFFS  = 4;

    typedef enum logic [JT_W-1:0] {
        JT_NONE   = 3'b000,
        JT_ZERO   = 3'b001,
        JT_NEG    = 3'b010,
        JT_CARRY  = 3'b011,
        JT_ALWAYS = 3'b100
    } jtype_e;

    localparam int JT_CODES = 5;
endpackage

// File: rtl/npc_seq_adder.sv
// Sequential successor: adds 2 or 4 bytes to the PC.
// Assumes the sum wraps modulo 2^ADDR_W (carry out dropped).
module npc_seq_adder #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              has_offset_i,
    output logic [ADDR_W-1:0] seq_o
);
    import npc_pkg::*;
    localparam logic [ADDR_W-1:0] INC_PLAIN = ADDR_W'(STEP_PLAIN);
    localparam logic [ADDR_W-1:0] INC_OFFS  = ADDR_W'(STEP_OFFS);

    // Choose the step and add it with wrap.
    always_comb begin
        seq_o = pc_i + (has_offset_i ? INC_OFFS : INC_PLAIN);
    end
endmodule

// File: rtl/npc_jump_eval.sv
// Jump evaluation: one-hot decode of the jump-type code, each line
// qualified by its flag, ORed into a single taken signal.
// Assumes codes beyond the defined set mean "no jump".
module npc_jump_eval (
    input  logic [npc_pkg::JT_W-1:0] jtype_i,
    input  logic                     flag_c_i,
    input  logic                     flag_n_i,
    input  logic                     flag_z_i,
    output logic                     taken_o
);
    import npc_pkg::*;
    logic [JT_CODES-1:0] onehot;
    logic [JT_CODES-1:0] cond;

    // One decoder line per defined code.
    for (genvar g = 0; g < JT_CODES; g++) begin : g_dec
        assign onehot[g] = (jtype_i == JT_W'(g));
    end

    // Condition that qualifies each decoded line.
    always_comb begin
        cond            = '0;
        cond[JT_ZERO]   = flag_z_i;
        cond[JT_NEG]    = flag_n_i;
        cond[JT_CARRY]  = flag_c_i;
        cond[JT_ALWAYS] = 1'b1;
    end

    // AND each line with its flag and merge.
    always_comb begin
        taken_o = |(onehot & cond);
    end
endmodule

// File: rtl/npc_prio_chain.sv
// Three-level priority chain: jump over sequential, exception over
// that, return over everything.
// Assumes all selects are clean single-bit strobes.
module npc_prio_chain #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] seq_i,
    input  logic              jump_i,
    input  logic [ADDR_W-1:0] jump_dest_i,
    input  logic              exc_i,
    input  logic [ADDR_W-1:0] exc_addr_i,
    input  logic              ret_i,
    input  logic [ADDR_W-1:0] ret_addr_i,
    output logic [ADDR_W-1:0] next_o
);
    localparam int LEVELS = 3;
    logic [LEVELS:0][ADDR_W-1:0] stage;
    logic [LEVELS-1:0]           sel;
    logic [LEVELS-1:0][ADDR_W-1:0] alt;

    // Level inputs, lowest priority first.
    always_comb begin
        sel = {ret_i, exc_i, jump_i};
        alt = {ret_addr_i, exc_addr_i, jump_dest_i};
    end

    assign stage[0] = seq_i;
    // Each level overrides the one below it when selected.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign stage[g+1] = sel[g] ? alt[g] : stage[g];
    end

    assign next_o = stage[LEVELS];
endmodule

// File: rtl/npc_selector.sv
// Next-PC selector top: sequential adder, jump evaluation, priority
// chain and the PC register (synchronous active-low reset, stall hold).
// Assumes start_addr_i is valid whenever rst_n is low.
module npc_selector #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              has_offset_i,
    input  logic [2:0]        jump_type_i,
    input  logic              flag_c_i,
    input  logic              flag_n_i,
    input  logic              flag_z_i,
    input  logic [ADDR_W-1:0] jump_dest_i,
    input  logic              exc_i,
    input  logic [ADDR_W-1:0] exc_addr_i,
    input  logic              ret_i,
    input  logic [ADDR_W-1:0] ret_addr_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              jump_taken_o
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] seq_pc;
    logic              taken;
    logic [ADDR_W-1:0] next_pc;

    npc_seq_adder #(.ADDR_W(ADDR_W)) u_seq (
        .pc_i        (pc_q),
        .has_offset_i(has_offset_i),
        .seq_o       (seq_pc)
    );

    npc_jump_eval u_jmp (
        .jtype_i (jump_type_i),
        .flag_c_i(flag_c_i),
        .flag_n_i(flag_n_i),
        .flag_z_i(flag_z_i),
        .taken_o (taken)
    );

    npc_prio_chain #(.ADDR_W(ADDR_W)) u_chain (
        .seq_i      (seq_pc),
        .jump_i     (taken),
        .jump_dest_i(jump_dest_i),
        .exc_i      (exc_i),
        .exc_addr_i (exc_addr_i),
        .ret_i      (ret_i),
        .ret_addr_i (ret_addr_i),
        .next_o     (next_pc)
    );

    // PC register: reset to start address, else advance unless stalled.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc_q <= start_addr_i;
        else if (!stall_i) pc_q <= next_pc;
    end

    assign pc_o         = pc_q;
    assign next_pc_o    = next_pc;
    assign jump_taken_o = taken;

    AST_RESET_LOAD: assert property (@(posedge clk) !rst_n |=> pc_q == $past(start_addr_i)); // R1
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) stall_i |=> $stable(pc_q)); // R9
    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) !stall_i |=> pc_q == $past(next_pc)); // R10
    AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) jump_type_i == 3'b100 |-> taken); // R4
    AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n) (jump_type_i == 3'b000 || jump_type_i[2:0] > 3'b100) |-> !taken); // R5
    AST_EXC_OVER: assert property (@(posedge clk) disable iff (!rst_n) (exc_i && !ret_i) |-> next_pc == exc_addr_i); // R7
    AST_RET_OVER: assert property (@(posedge clk) disable iff (!rst_n) ret_i |-> next_pc == ret_addr_i); // R8
endmodule

// File: tb/npc_selector_tb.sv
// Bench for npc_selector: a behavioural model compared every cycle.
module npc_selector_tb_top;
    localparam int AW     = 20;
    localparam int CLK_PS = 10;
    localparam longint MASK = (64'd1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n, stall, has_off, fc, fn, fz, exc, ret;
    logic [2:0]    jt;
    logic [AW-1:0] start, jdest, eaddr, raddr;
    logic [AW-1:0] pc_o, next_pc_o;
    logic          taken_o;

    int checks = 0;
    int errors = 0;
    longint exp_pc = 0;

    always #(CLK_PS/2) clk = ~clk;

    npc_selector #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .stall_i(stall), .start_addr_i(start),
        .has_offset_i(has_off), .jump_type_i(jt), .flag_c_i(fc),
        .flag_n_i(fn), .flag_z_i(fz), .jump_dest_i(jdest), .exc_i(exc),
        .exc_addr_i(eaddr), .ret_i(ret), .ret_addr_i(raddr),
        .pc_o(pc_o), .next_pc_o(next_pc_o), .jump_taken_o(taken_o)
    );

    function automatic bit model_taken(logic [2:0] t, logic c, logic n, logic z);
        case (t)
            3'd1: return z;
            3'd2: return n;
            3'd3: return c;
            3'd4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic longint model_next();
        longint v;
        v = (exp_pc + (has_off ? 4 : 2)) & MASK;
        if (model_taken(jt, fc, fn, fz)) v = jdest;
        if (exc) v = eaddr;
        if (ret) v = raddr;
        return v;
    endfunction

    task automatic check(string req, string what, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // One cycle: inputs already driven after negedge; check, then clock.
    task automatic step(string req);
        longint nx;
        #1;
        nx = model_next();
        if (rst_n) begin
            check(req, "pc", pc_o, exp_pc);
            check(req, "next_pc", next_pc_o, nx);
            check(req, "taken", taken_o, model_taken(jt, fc, fn, fz));
        end
        @(posedge clk);
        if (!rst_n) exp_pc = start;
        else if (!stall) exp_pc = nx;
        @(negedge clk);
    endtask

    task automatic idle();
        stall = 0; has_off = 0; jt = 3'd0; fc = 0; fn = 0; fz = 0;
        exc = 0; ret = 0; jdest = 20'h0A000; eaddr = 20'h00100; raddr = 20'h05550;
    endtask

    initial begin
        #(CLK_PS * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0; start = 20'h00040;
        @(negedge clk);
        step("R1");
        step("R1");
        rst_n = 1;
        check("R1", "pc after reset", pc_o, 20'h00040);
        step("R2"); step("R2");
        has_off = 1; step("R3"); step("R3");
        // wrap at top of address space
        rst_n = 0; start = 20'hFFFFE; step("R1"); rst_n = 1;
        has_off = 1; step("R3");
        check("R3", "pc wrapped", pc_o, 20'h00002);
        has_off = 0;
        // each conditional code with flag low then high
        for (int code = 1; code <= 3; code++) begin
            jt = 3'(code); fc = 0; fn = 0; fz = 0; step("R4");
            fz = (code == 1); fn = (code == 2); fc = (code == 3); step("R4");
        end
        jt = 3'd4; fc = 0; fn = 0; fz = 0; step("R4");
        // unused codes with all flags set
        fc = 1; fn = 1; fz = 1;
        for (int code = 5; code <= 7; code++) begin
            jt = 3'(code); step("R5");
        end
        jt = 3'd0; step("R5");
        jt = 3'd1; jdest = 20'h12344; step("R6");
        // collisions
        jt = 3'd4; exc = 1; step("R7");
        has_off = 1; ret = 1; step("R8");
        ret = 1; exc = 0; jt = 0; step("R8");
        idle();
        stall = 1; step("R9"); step("R9");
        stall = 0; step("R10");
        // random mix
        for (int i = 0; i < 400; i++) begin
            stall   = ($urandom % 4) == 0;
            has_off = $urandom % 2;
            jt      = 3'($urandom % 8);
            fc = $urandom % 2; fn = $urandom % 2; fz = $urandom % 2;
            jdest = AW'($urandom); eaddr = AW'($urandom); raddr = AW'($urandom);
            exc = ($urandom % 3) == 0;
            ret = ($urandom % 4) == 0;
            rst_n = ($urandom % 50) != 0;
            start = AW'($urandom);
            step(ret ? "R8" : exc ? "R7" : stall ? "R9" : "R10");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule